// File: doc/BRIEF.md
# Offset-corrected RMS calculator

The block turns a stream of signed 24-bit current samples, already stripped of DC, into a 24-bit unsigned RMS value. Each accepted sample is squared. The square goes into a first-order IIR low-pass stage whose state is the running mean square. A programmable signed 12-bit correction term, scaled by 32768 per LSB, is added to that mean square. The sum is clamped at zero, and a bit-serial non-restoring square-root engine takes its integer root. The correction is applied before the root. The value written is therefore the one that satisfies RMS = sqrt(RMS0² + CORR × 32768), where RMS0 is the uncorrected result.

A host writes the correction term through a write strobe. It picks up each new result when a one-cycle valid pulse appears. At full scale the samples peak at about ±2,642,412 (0x2851EC / 0xD7AE14). A full-scale sine then settles to about 1,868,467 (0x1C82B3).

The root engine is a state machine with three states. RT_IDLE waits for a filter update and moves to RT_CALC when one arrives, latching the corrected radicand. RT_CALC produces one root bit per clock and moves to RT_DONE after 24 bits. RT_DONE loads the output register, pulses valid, and always returns to RT_IDLE.

Top module: `rms_offset_calc`

## Requirements
- R1: A synchronous active-high `rst` clears the mean-square state, the correction register and `rms_out`. It also drops `rms_valid`, and all three stay at zero until new samples arrive.
- R2: Each sample accepted with `smp_valid` updates the mean square M at that clock edge, as M ← M + floor((x² − M) / 2^K) with K = 4 by default. M changes at no other edge.
- R3: A sample accepted while the root engine is idle produces a one-cycle `rms_valid` pulse. The pulse is visible in the cycle after the 26th rising edge that follows the accepting edge, and `rms_valid` is low in the cycle before it.
- R4: The reported value is floor(sqrt(max(0, M + C × 32768))). M is the mean square after the triggering sample, and C is the correction register at the edge after that sample.
- R5: `ofs_wdata` is a 12-bit two's-complement value C in the range −2048…2047. It is stored at a clock edge where `ofs_wr` is high, and each LSB changes the radicand by 32768.
- R6: When M + C × 32768 is negative, the radicand is clamped to zero and the reported value is 0.
- R7: `rms_out` changes only at the edge where `rms_valid` rises, and holds its value in every other cycle.
- R8: A sample accepted while a root is in progress updates M but starts no new root. Only one pulse results, and it carries the value computed from the earlier radicand.
- R9: A full-scale sine (peak 2,642,412, eight samples per period) with C = 0 settles to within 5 % of 1,868,467.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed input sample |
| ofs_wr | input | 1 | Correction register write strobe |
| ofs_wdata | input | 12 | Signed correction value |
| rms_out | output | 24 | Unsigned RMS result register |
| rms_valid | output | 1 | One-cycle pulse when `rms_out` is loaded |

## Verification
The mean square moves at the edge that accepts a sample, and the root starts one edge later. Twenty-four iteration edges and the RT_DONE edge follow, so the result is due 26 edges after the sample. Every sample task waits exactly 25 edges and checks that `rms_valid` is still low. It then waits one more edge and checks the pulse and the value on the falling edge. For the busy case, a second sample lands five edges into a root computation. The bench expects the pulse at the same 26-edge point, carrying the first radicand's root, and then watches 35 further cycles for silence with `rms_out` held.

// File: rtl/rms_pkg.sv
package rms_pkg;

    // Root engine sequencing
    typedef enum logic [1:0] {
        RT_IDLE = 2'd0,
        RT_CALC = 2'd1,
        RT_DONE = 2'd2
    } root_state_t;

    localparam int SMP_W_DEF  = 24;
    localparam int CORR_W_DEF = 12;
    localparam int LPF_K_DEF  = 4;
    localparam int CORR_SH_DEF = 15;

endpackage

// File: rtl/rms_square_lpf.sv
module rms_square_lpf #(
    parameter int SMP_W = 24,
    parameter int LPF_K = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic [SMP_W-1:0]     smp_data,
    output logic [2*SMP_W-1:0]   ms_q,
    output logic                 ms_upd
);
    localparam int SQ_W   = 2 * SMP_W;
    localparam int DIFF_W = SQ_W + 2;

    logic signed [SQ_W-1:0]   sq;
    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] step;
    logic signed [DIFF_W-1:0] ms_next;

    always_comb begin
        sq      = $signed(smp_data) * $signed(smp_data);
        diff    = $signed({2'b00, sq}) - $signed({2'b00, ms_q});
        step    = diff >>> LPF_K;
        ms_next = $signed({2'b00, ms_q}) + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_q   <= '0;
            ms_upd <= 1'b0;
        end else begin
            ms_upd <= smp_valid;
            if (smp_valid) begin
                ms_q <= ms_next[SQ_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rms_ofs_adj.sv
module rms_ofs_adj #(
    parameter int SQ_W    = 48,
    parameter int CORR_W  = 12,
    parameter int CORR_SH = 15
) (
    input  logic [SQ_W-1:0]   ms_q,
    input  logic [CORR_W-1:0] corr,
    output logic [SQ_W-1:0]   rad
);
    localparam int SUM_W = SQ_W + 2;

    logic signed [SUM_W-1:0] corr_ext;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        corr_ext = SUM_W'($signed(corr)) <<< CORR_SH;
        sum      = $signed({2'b00, ms_q}) + corr_ext;
        if (sum[SUM_W-1]) begin
            rad = '0;
        end else begin
            rad = sum[SQ_W-1:0];
        end
    end
endmodule

// File: rtl/rms_isqrt.sv
module rms_isqrt
    import rms_pkg::*;
#(
    parameter int N = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2*N-1:0]   rad,
    output logic             busy,
    output logic [N-1:0]     root,
    output logic             root_valid
);
    localparam int RMW = N + 4;
    localparam int CW  = $clog2(N);

    root_state_t      state_q, state_d;
    logic [2*N-1:0]   d_sh;
    logic [RMW-1:0]   rem_q;
    logic [N-1:0]     q_q;
    logic [CW-1:0]    cnt_q;

    logic [RMW-1:0]   rem_sh;
    logic [RMW-1:0]   trial;
    logic [RMW-1:0]   rem_n;
    logic [N-1:0]     q_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_IDLE: if (start) state_d = RT_CALC;
            RT_CALC: if (cnt_q == '0) state_d = RT_DONE;
            RT_DONE: state_d = RT_IDLE;
            default: state_d = RT_IDLE;
        endcase
    end

    // one non-restoring step
    always_comb begin
        rem_sh = {rem_q[RMW-3:0], d_sh[2*N-1:2*N-2]};
        trial  = {{(RMW-N-2){1'b0}}, q_q, rem_q[RMW-1], 1'b1};
        if (rem_q[RMW-1]) begin
            rem_n = rem_sh + trial;
        end else begin
            rem_n = rem_sh - trial;
        end
        q_n = {q_q[N-2:0], ~rem_n[RMW-1]};
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            d_sh       <= '0;
            rem_q      <= '0;
            q_q        <= '0;
            cnt_q      <= '0;
            root       <= '0;
            root_valid <= 1'b0;
        end else begin
            root_valid <= 1'b0;
            unique case (state_q)
                RT_IDLE: begin
                    if (start) begin
                        d_sh  <= rad;
                        rem_q <= '0;
                        q_q   <= '0;
                        cnt_q <= CW'(N - 1);
                    end
                end
                RT_CALC: begin
                    d_sh  <= d_sh << 2;
                    rem_q <= rem_n;
                    q_q   <= q_n;
                    cnt_q <= cnt_q - 1'b1;
                end
                RT_DONE: begin
                    root       <= q_q;
                    root_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != RT_IDLE);
endmodule

// File: rtl/rms_offset_calc.sv
module rms_offset_calc
    import rms_pkg::*;
#(
    parameter int SMP_W   = SMP_W_DEF,
    parameter int CORR_W  = CORR_W_DEF,
    parameter int LPF_K   = LPF_K_DEF,
    parameter int CORR_SH = CORR_SH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              ofs_wr,
    input  logic [CORR_W-1:0] ofs_wdata,
    output logic [SMP_W-1:0]  rms_out,
    output logic              rms_valid
);
    localparam int SQ_W = 2 * SMP_W;

    logic [SQ_W-1:0]   ms_q;
    logic              ms_upd;
    logic [CORR_W-1:0] corr_q;
    logic [SQ_W-1:0]   rad_in;
    logic              root_busy;
    logic              root_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_q <= '0;
        end else if (ofs_wr) begin
            corr_q <= ofs_wdata;
        end
    end

    rms_square_lpf #(
        .SMP_W (SMP_W),
        .LPF_K (LPF_K)
    ) lpf_i (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .ms_q      (ms_q),
        .ms_upd    (ms_upd)
    );

    rms_ofs_adj #(
        .SQ_W    (SQ_W),
        .CORR_W  (CORR_W),
        .CORR_SH (CORR_SH)
    ) adj_i (
        .ms_q (ms_q),
        .corr (corr_q),
        .rad  (rad_in)
    );

    assign root_start = ms_upd & ~root_busy;

    rms_isqrt #(
        .N (SMP_W)
    ) root_i (
        .clk        (clk),
        .rst        (rst),
        .start      (root_start),
        .rad        (rad_in),
        .busy       (root_busy),
        .root       (rms_out),
        .root_valid (rms_valid)
    );
endmodule

// File: rtl/rms_offset_calc_chk.sv
module rms_offset_calc_chk #(
    parameter int SMP_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic               rms_valid,
    input  logic [SMP_W-1:0]   rms_out,
    input  logic [2*SMP_W-1:0] ms_q,
    input  logic               root_start,
    input  logic [2*SMP_W-1:0] rad_in
);
    localparam int PW = 2 * SMP_W + 2;

    logic [2*SMP_W-1:0] chk_rad;
    logic [PW-1:0]      lo_sq;
    logic [PW-1:0]      hi_sq;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_rad <= '0;
        end else if (root_start) begin
            chk_rad <= rad_in;
        end
    end

    assign lo_sq = PW'(rms_out) * PW'(rms_out);
    assign hi_sq = (PW'(rms_out) + 1'b1) * (PW'(rms_out) + 1'b1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rms_out == '0 && !rms_valid));

    // R2
    ms_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_valid) |-> $stable(ms_q));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rms_valid |=> !rms_valid);

    // R4
    root_range_chk: assert property (@(posedge clk) disable iff (rst)
        rms_valid |-> (lo_sq <= PW'(chk_rad) && hi_sq > PW'(chk_rad)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rms_valid |-> rms_out == $past(rms_out));
endmodule

bind rms_offset_calc rms_offset_calc_chk #(.SMP_W(SMP_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .rms_valid  (rms_valid),
    .rms_out    (rms_out),
    .ms_q       (ms_q),
    .root_start (root_start),
    .rad_in     (rad_in)
);

// File: tb/rms_offset_calc_tb_top.sv
module rms_offset_calc_tb_top;
    localparam int K = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic        ofs_wr = 1'b0;
    logic [11:0] ofs_wdata = '0;
    logic [23:0] rms_out;
    logic        rms_valid;

    int     total = 0;
    int     bad = 0;
    longint m_ms = 0;
    int     m_ofs = 0;
    longint last_exp = 0;

    always #2 clk = ~clk;

    rms_offset_calc dut_i (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .ofs_wr    (ofs_wr),
        .ofs_wdata (ofs_wdata),
        .rms_out   (rms_out),
        .rms_valid (rms_valid)
    );

    function automatic longint isqrt(input longint v);
        longint r = 0;
        for (int b = 23; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    function automatic longint model_step(input longint ms, input int x);
        longint sq = longint'(x) * longint'(x);
        longint d  = sq - ms;
        return ms + (d >>> K);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_ms = 0;
        m_ofs = 0;
    endtask

    task automatic write_ofs(input int v);
        @(negedge clk);
        ofs_wr = 1'b1;
        ofs_wdata = v[11:0];
        @(posedge clk);
        #1 ofs_wr = 1'b0;
        m_ofs = v;
    endtask

    // drives one sample, checks the 26-edge timing and the value
    task automatic run_sample(input int x, input string req);
        longint corr;
        string   tag;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = x[23:0];
        @(posedge clk);
        #1 smp_valid = 1'b0;
        m_ms = model_step(m_ms, x);
        corr = m_ms + longint'(m_ofs) * 32768;
        tag  = req;
        if (corr < 0) begin
            corr = 0;
            tag = "R6";
        end
        last_exp = isqrt(corr);
        repeat (25) @(posedge clk);
        @(negedge clk);
        chk(rms_valid == 1'b0, "R3 early", longint'(rms_valid), 0);
        @(posedge clk);
        @(negedge clk);
        chk(rms_valid == 1'b1, "R3 pulse", longint'(rms_valid), 1);
        chk(longint'(rms_out) == last_exp, tag, longint'(rms_out), last_exp);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int amps[5] = '{0, 1000, 300000, 2642412, -2642412};
        int offs[9] = '{-2048, -1024, -300, -1, 0, 1, 77, 1023, 2047};
        longint held;
        real v;
        int x;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rms_out == 24'd0, "R1", longint'(rms_out), 0);
        chk(rms_valid == 1'b0, "R1", longint'(rms_valid), 0);

        // R2 R4 R5 R6: sweep DC levels against signed corrections
        foreach (amps[a]) begin
            foreach (offs[o]) begin
                write_ofs(offs[o]);
                run_sample(amps[a], (offs[o] == 0) ? "R2" : "R5");
            end
        end

        // R6: strong negative correction on a small mean square
        do_reset();
        write_ofs(-2048);
        run_sample(5000, "R6");
        chk(rms_out == 24'd0, "R6", longint'(rms_out), 0);

        // R8: second sample while root busy, then R7 hold
        write_ofs(10);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 24'd400000;
        @(posedge clk);
        #1 smp_valid = 1'b0;
        m_ms = model_step(m_ms, 400000);
        last_exp = isqrt(m_ms + longint'(m_ofs) * 32768);
        repeat (4) @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 24'd50;
        @(posedge clk);
        #1 smp_valid = 1'b0;
        m_ms = model_step(m_ms, 50);
        repeat (21) @(posedge clk);
        @(negedge clk);
        chk(rms_valid == 1'b1, "R8 pulse", longint'(rms_valid), 1);
        chk(longint'(rms_out) == last_exp, "R8", longint'(rms_out), last_exp);
        held = longint'(rms_out);
        begin
            int pulses = 0;
            int moved = 0;
            for (int c = 0; c < 35; c++) begin
                @(negedge clk);
                if (rms_valid) pulses++;
                if (longint'(rms_out) != held) moved++;
            end
            chk(pulses == 0, "R8 no second pulse", pulses, 0);
            chk(moved == 0, "R7", moved, 0);
        end

        // R1: reset clears correction and mean square
        write_ofs(2047);
        do_reset();
        run_sample(0, "R1");
        chk(rms_out == 24'd0, "R1 cleared", longint'(rms_out), 0);

        // R9: full-scale sine, no correction
        write_ofs(0);
        for (int i = 0; i < 240; i++) begin
            v = 2642412.0 * $sin(2.0 * 3.14159265358979 * i / 8.0);
            x = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
            run_sample(x, "R9 model");
            if (i >= 232) begin
                chk(rms_out > 24'd1775044 && rms_out < 24'd1961890, "R9",
                    longint'(rms_out), 1868467);
            end
        end

        // R5: small sine with a positive correction
        write_ofs(200);
        for (int i = 0; i < 96; i++) begin
            v = 26424.0 * $sin(2.0 * 3.14159265358979 * i / 8.0);
            x = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
            run_sample(x, "R5");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule